// File: doc/BRIEF.md
# Dual-View 64-bit Cycle and Retirement Counters

This block keeps two free-running 64-bit event counters for a core with a 32-bit register datapath. One counts clock cycles. The other counts cycles in which the pipeline reports a retired instruction. Each counter is split into a lower and an upper 32-bit word, and each word has its own register address.

Every counter can be reached through two address windows. The first is a read-only window that any privilege level may read. The second is a read/write window that only machine mode may use. Both windows show the same 64-bit state, so the read-only window lets lower privilege levels sample the counters without a trap. A machine-mode mask register can freeze either counter.

The block decodes one register access per cycle. The address, privilege, write enable and write data are presented together. Read data and the illegal flag are combinational from those inputs. A legal write takes effect on the next rising clock edge.

Top module: `perf_counter_csr`

## Requirements
- R1: When its freeze bit is clear, the cycle counter advances by exactly one on every rising clock edge that has no legal write to it.
- R2: When its freeze bit is clear, the retirement counter advances by one on each edge where `retire_i` is high. It holds its value when `retire_i` is low, and a legal write to it overrides either case.
- R3: The freeze mask sits at address 0x320 and resets to 0. Bit 0 freezes the cycle counter and bit 2 freezes the retirement counter. Bit 1 and bits 31:3 always read as 0, whatever value was written.
- R4: The read-only window is 0xC00 (cycles, bits 31:0), 0xC80 (cycles, bits 63:32), 0xC02 (retired, bits 31:0) and 0xC82 (retired, bits 63:32). It may be read at any privilege, and it returns the same value as the matching machine address.
- R5: The machine window is 0xB00/0xB80 (cycles, low/high) and 0xB02/0xB82 (retired, low/high). This window and 0x320 need privilege 3. Privilege is encoded as 0 = user, 1 = supervisor, 3 = machine, and a value of 2 ranks below machine.
- R6: A legal write to a low or high word replaces only those 32 bits. The other word keeps its value, and no increment happens on that edge.
- R7: An increment carries from bit 31 into bit 32, so the two words form one 64-bit count.
- R8: `illegal_o` is high when the address is unmapped, or when the privilege is below address bits 9:8, or when a write targets an address whose bits 11:10 are 2'b11. An illegal access changes no state, and while `illegal_o` is high `rdata_o` is 0.
- R9: A synchronous low `rst_n` clears both counters and the freeze mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| csr_addr_i | input | 12 | Register address of the access |
| priv_i | input | 2 | Privilege of the access |
| csr_we_i | input | 1 | Access is a write |
| csr_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when illegal |
| illegal_o | output | 1 | Access is illegal |

## Verification
Two pairs of functions can act on the same clock edge. In the first pair, a machine write to the retirement counter arrives in the same cycle as a high retire strobe. The bench drives both together and expects the counter to hold exactly the written word, with no extra count and the other word unchanged. In the second pair, a lower-word carry lands on the edge right after the freeze mask is released. The bench loads 0xFFFFFFFE into the low word while the counter is frozen, releases the mask, and expects the high word to step by one exactly two edges later. The privilege and access rules are swept over every privilege, every read or write, and a list of mapped and unmapped addresses. The result of each sweep point is predicted arithmetically from the address fields.

// File: rtl/perf_csr_pkg.sv
// Shared address constants and access-select type for the counter block.
// Assumes a 12-bit register address space whose bits 11:10 mark
// read-only space (2'b11) and whose bits 9:8 give the minimum privilege.
package perf_csr_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CYC_LO_RO = 12'hC00;
    localparam logic [ADDR_W-1:0] A_CYC_HI_RO = 12'hC80;
    localparam logic [ADDR_W-1:0] A_RET_LO_RO = 12'hC02;
    localparam logic [ADDR_W-1:0] A_RET_HI_RO = 12'hC82;
    localparam logic [ADDR_W-1:0] A_CYC_LO_RW = 12'hB00;
    localparam logic [ADDR_W-1:0] A_CYC_HI_RW = 12'hB80;
    localparam logic [ADDR_W-1:0] A_RET_LO_RW = 12'hB02;
    localparam logic [ADDR_W-1:0] A_RET_HI_RW = 12'hB82;
    localparam logic [ADDR_W-1:0] A_FREEZE    = 12'h320;

    // Which piece of state an access addresses.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI,
        SEL_FREEZE
    } csr_sel_e;

endpackage

// File: rtl/perf_csr_decode.sv
// Address and permission decoder.
// Maps an address to the state it selects. It flags an access as illegal
// when the address is unmapped, when the privilege is too low, or when a
// write targets read-only space. Purely combinational.
module perf_csr_decode
    import perf_csr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              we_i,
    output csr_sel_e          sel_o,
    output logic              illegal_o,
    output logic              wr_ok_o
);

    logic read_only_space;
    logic priv_short;

    // Select the addressed state; both windows map to the same selects.
    always_comb begin
        unique case (addr_i)
            A_CYC_LO_RO, A_CYC_LO_RW: sel_o = SEL_CYC_LO;
            A_CYC_HI_RO, A_CYC_HI_RW: sel_o = SEL_CYC_HI;
            A_RET_LO_RO, A_RET_LO_RW: sel_o = SEL_RET_LO;
            A_RET_HI_RO, A_RET_HI_RW: sel_o = SEL_RET_HI;
            A_FREEZE:                 sel_o = SEL_FREEZE;
            default:                  sel_o = SEL_NONE;
        endcase
    end

    // Permission checks taken from the address fields.
    always_comb begin
        read_only_space = (addr_i[11:10] == 2'b11);
        priv_short      = (priv_i < addr_i[9:8]);
        illegal_o       = (sel_o == SEL_NONE) || priv_short || (we_i && read_only_space);
        wr_ok_o         = we_i && !illegal_o;
    end

endmodule

// File: rtl/perf_counter_word_pair.sv
// One 64-bit event counter built as two independently writable words.
// A write to either word wins over the increment on that edge and leaves
// the other word as it was. Assumes at most one word write per cycle.
module perf_counter_word_pair #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [2*DATA_W-1:0] count_o
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] count_q;

    // Counter update: reset, word write, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_lo_i) begin
            count_q <= {count_q[CNT_W-1:DATA_W], wdata_i};
        end else if (wr_hi_i) begin
            count_q <= {wdata_i, count_q[DATA_W-1:0]};
        end else if (inc_i) begin
            count_q <= count_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/perf_freeze_mask.sv
// Per-counter freeze mask. Only the bit positions set in KEEP_MASK hold
// state; every other bit is tied to zero and ignores writes.
module perf_freeze_mask #(
    parameter int          MASK_W    = 3,
    parameter logic [2:0]  KEEP_MASK = 3'b101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [MASK_W-1:0] wdata_i,
    output logic [MASK_W-1:0] mask_o
);

    logic [MASK_W-1:0] mask_q;

    // Mask register; unsupported bits are dropped on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i & KEEP_MASK[MASK_W-1:0];
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/perf_counter_csr.sv
// Top level: cycle and retirement counters with a read-only window for
// any privilege, a machine-only read/write window and a freeze mask.
// Assumes one register access per cycle, presented on the csr_* inputs.
// Read data and the illegal flag are combinational from those inputs.
module perf_counter_csr
    import perf_csr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [1:0]        priv_i,
    input  logic              csr_we_i,
    input  logic [DATA_W-1:0] csr_wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              illegal_o
);

    localparam int CNT_W   = 2 * DATA_W;
    localparam int NUM_CNT = 2;
    localparam int MASK_W  = 3;

    csr_sel_e           sel;
    logic               wr_ok;
    logic [MASK_W-1:0]  freeze_mask;
    logic [NUM_CNT-1:0] inc_src;
    logic [NUM_CNT-1:0] wr_lo;
    logic [NUM_CNT-1:0] wr_hi;
    logic [CNT_W-1:0]   counts [NUM_CNT];
    logic [CNT_W-1:0]   cycle_count;
    logic [CNT_W-1:0]   retire_count;

    perf_csr_decode u_decode (
        .addr_i    (csr_addr_i),
        .priv_i    (priv_i),
        .we_i      (csr_we_i),
        .sel_o     (sel),
        .illegal_o (illegal_o),
        .wr_ok_o   (wr_ok)
    );

    perf_freeze_mask #(
        .MASK_W    (MASK_W),
        .KEEP_MASK (3'b101)
    ) u_freeze (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ok && (sel == SEL_FREEZE)),
        .wdata_i (csr_wdata_i[MASK_W-1:0]),
        .mask_o  (freeze_mask)
    );

    // Event sources: index 0 counts clocks, index 1 counts retirements.
    always_comb begin
        inc_src[0] = 1'b1;
        inc_src[1] = retire_i;
        wr_lo[0]   = wr_ok && (sel == SEL_CYC_LO);
        wr_hi[0]   = wr_ok && (sel == SEL_CYC_HI);
        wr_lo[1]   = wr_ok && (sel == SEL_RET_LO);
        wr_hi[1]   = wr_ok && (sel == SEL_RET_HI);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int FREEZE_BIT = (g == 0) ? 0 : 2;
        perf_counter_word_pair #(
            .DATA_W (DATA_W)
        ) u_word_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc_src[g] && !freeze_mask[FREEZE_BIT]),
            .wr_lo_i (wr_lo[g]),
            .wr_hi_i (wr_hi[g]),
            .wdata_i (csr_wdata_i),
            .count_o (counts[g])
        );
    end

    assign cycle_count  = counts[0];
    assign retire_count = counts[1];

    // Read-back mux; illegal accesses return zero.
    always_comb begin
        rdata_o = '0;
        if (!illegal_o) begin
            unique case (sel)
                SEL_CYC_LO: rdata_o = cycle_count[DATA_W-1:0];
                SEL_CYC_HI: rdata_o = cycle_count[CNT_W-1:DATA_W];
                SEL_RET_LO: rdata_o = retire_count[DATA_W-1:0];
                SEL_RET_HI: rdata_o = retire_count[CNT_W-1:DATA_W];
                SEL_FREEZE: rdata_o = {{(DATA_W-MASK_W){1'b0}}, freeze_mask};
                default:    rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/perf_counter_csr_chk.sv
// Property checker bound to the top module. It watches the ports and the
// two counter values and checks stepping, freezing, word writes and the
// access rules.
module perf_counter_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        retire_i,
    input logic [11:0] csr_addr_i,
    input logic [1:0]  priv_i,
    input logic        csr_we_i,
    input logic [31:0] csr_wdata_i,
    input logic        illegal_o,
    input logic [63:0] cycle_count,
    input logic [63:0] retire_count,
    input logic [31:0] rdata_o
);

    logic wr_legal;
    logic cyc_wr;
    logic ret_wr;
    logic frz_wr;

    // Legal-write classification derived from the ports only.
    always_comb begin
        wr_legal = csr_we_i && !illegal_o;
        cyc_wr   = wr_legal && (csr_addr_i == 12'hB00 || csr_addr_i == 12'hB80);
        ret_wr   = wr_legal && (csr_addr_i == 12'hB02 || csr_addr_i == 12'hB82);
        frz_wr   = wr_legal && (csr_addr_i == 12'h320);
    end

    // Track the freeze bits from legal writes to the mask address.
    logic frz_cyc;
    logic frz_ret;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_cyc <= 1'b0;
            frz_ret <= 1'b0;
        end else if (frz_wr) begin
            frz_cyc <= csr_wdata_i[0];
            frz_ret <= csr_wdata_i[2];
        end
    end

    assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_cyc && !cyc_wr) |=> (cycle_count == $past(cycle_count) + 64'd1));

    assert_retire_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_ret && !ret_wr && retire_i) |=> (retire_count == $past(retire_count) + 64'd1));

    assert_retire_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_wr && !retire_i) |=> $stable(retire_count));

    assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_cyc && !cyc_wr && !frz_wr) |=> $stable(cycle_count));

    assert_lo_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_legal && csr_addr_i == 12'hB00) |=>
        (cycle_count[31:0] == $past(csr_wdata_i) && cycle_count[63:32] == $past(cycle_count[63:32])));

    assert_hi_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_legal && csr_addr_i == 12'hB82) |=>
        (retire_count[63:32] == $past(csr_wdata_i) && retire_count[31:0] == $past(retire_count[31:0])));

    assert_machine_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr_i[11:8] == 4'hB && priv_i != 2'd3) |-> illegal_o);

    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_addr_i[11:10] == 2'b11) |-> (illegal_o && rdata_o == 32'd0));

endmodule

bind perf_counter_csr perf_counter_csr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_i     (retire_i),
    .csr_addr_i   (csr_addr_i),
    .priv_i       (priv_i),
    .csr_we_i     (csr_we_i),
    .csr_wdata_i  (csr_wdata_i),
    .illegal_o    (illegal_o),
    .cycle_count  (cycle_count),
    .retire_count (retire_count),
    .rdata_o      (rdata_o)
);

// File: tb/perf_counter_csr_test.sv
`timescale 1ns/1ps
module perf_counter_csr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_i = 1'b0;
    logic [11:0] csr_addr_i = 12'h000;
    logic [1:0]  priv_i = 2'd3;
    logic        csr_we_i = 1'b0;
    logic [31:0] csr_wdata_i = 32'd0;
    logic [31:0] rdata_o;
    logic        illegal_o;

    int checks = 0;
    int failures = 0;

    perf_counter_csr uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_i    (retire_i),
        .csr_addr_i  (csr_addr_i),
        .priv_i      (priv_i),
        .csr_we_i    (csr_we_i),
        .csr_wdata_i (csr_wdata_i),
        .rdata_o     (rdata_o),
        .illegal_o   (illegal_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Legal or illegal write with optional retire pulse; returns at next negedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] p, input logic ret);
        @(negedge clk);
        csr_addr_i = a; csr_wdata_i = d; priv_i = p; csr_we_i = 1'b1; retire_i = ret;
        @(posedge clk);
        @(negedge clk);
        csr_we_i = 1'b0; retire_i = 1'b0;
    endtask

    // Combinational read; call just after a negedge.
    task automatic rd(input logic [11:0] a, input logic [1:0] p, output logic [31:0] d, output logic ill);
        csr_addr_i = a; priv_i = p; csr_we_i = 1'b0;
        #2;
        d = rdata_o; ill = illegal_o;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        logic ill;
        int expc;
        logic [11:0] alist [14];
        alist = '{12'hC00, 12'hC80, 12'hC02, 12'hC82, 12'hB00, 12'hB80, 12'hB02,
                  12'hB82, 12'h320, 12'hC01, 12'hB01, 12'hC81, 12'h321, 12'h7B0};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R9 / R1: one edge out of reset the cycle count is 1
        rd(12'hC00, 2'd0, d, ill); check("R9 R1 cycle after reset", d, 32'd1);
        rd(12'hC80, 2'd0, d, ill); check("R9 cycle high", d, 32'd0);
        rd(12'hC02, 2'd0, d, ill); check("R9 retire low", d, 32'd0);
        rd(12'hC82, 2'd0, d, ill); check("R9 retire high", d, 32'd0);
        rd(12'h320, 2'd3, d, ill); check("R9 R3 freeze reset", d, 32'd0);

        // R1 / R6: load low word, then count k edges
        for (int k = 1; k <= 7; k += 3) begin
            wr(12'hB00, 32'h1000 * k, 2'd3, 1'b0);
            repeat (k) @(posedge clk);
            @(negedge clk);
            rd(12'hC00, 2'd1, d, ill);
            check("R1 cycle steps", d, 32'h1000 * k + k);
        end

        // R6 / R4: high-word write seen identically through both windows
        wr(12'hB80, 32'hA5A5_0001, 2'd3, 1'b0);
        rd(12'hC80, 2'd0, d, ill); rd(12'hB80, 2'd3, d2, ill);
        check("R4 R6 high via shadow", d, 32'hA5A5_0001);
        check("R4 same in both windows", d2, d);

        // R3 / R7: freeze, preload near carry, release, expect carry
        wr(12'h320, 32'd1, 2'd3, 1'b0);
        wr(12'hB80, 32'd5, 2'd3, 1'b0);
        wr(12'hB00, 32'hFFFF_FFFE, 2'd3, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(12'hC00, 2'd0, d, ill); check("R3 cycle frozen", d, 32'hFFFF_FFFE);
        wr(12'h320, 32'd0, 2'd3, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(12'hC80, 2'd0, d, ill); check("R7 carry into high", d, 32'd6);
        rd(12'hC00, 2'd0, d, ill); check("R7 low wrapped", d, 32'd0);

        // R2: retirement patterns
        wr(12'hB82, 32'd0, 2'd3, 1'b0);
        wr(12'hB02, 32'd0, 2'd3, 1'b0);
        for (int pat = 0; pat < 3; pat++) begin
            expc = 0;
            rd(12'hC02, 2'd0, d2, ill);
            for (int i = 0; i < 24; i++) begin
                retire_i = (pat == 0) ? i[0] : (pat == 1) ? (i % 4 != 3) : (i % 5 == 0);
                if (retire_i) expc++;
                @(negedge clk);
            end
            retire_i = 1'b0;
            @(negedge clk);
            rd(12'hC02, 2'd0, d, ill);
            check("R2 retire pattern", d - d2, expc);
        end

        // R3: freeze the retirement counter; bit 1 is not kept
        wr(12'h320, 32'hFFFF_FFFF, 2'd3, 1'b0);
        rd(12'h320, 2'd3, d, ill); check("R3 mask keeps bits 0 and 2", d, 32'd5);
        wr(12'h320, 32'd4, 2'd3, 1'b0);
        rd(12'hC02, 2'd0, d2, ill);
        retire_i = 1'b1;
        repeat (5) @(negedge clk);
        retire_i = 1'b0;
        rd(12'hC02, 2'd0, d, ill); check("R3 retire frozen", d, d2);
        wr(12'h320, 32'd0, 2'd3, 1'b0);

        // R6: write beats a same-cycle retire, other word untouched
        wr(12'hB82, 32'h0000_0077, 2'd3, 1'b0);
        wr(12'hB02, 32'h1234_5678, 2'd3, 1'b1);
        rd(12'hC02, 2'd0, d, ill); check("R6 write wins over retire", d, 32'h1234_5678);
        rd(12'hC82, 2'd0, d, ill); check("R6 high word kept", d, 32'h0000_0077);

        // R8: illegal writes change nothing and read zero
        wr(12'hC02, 32'hDEAD_BEEF, 2'd3, 1'b0);
        rd(12'hC02, 2'd0, d, ill); check("R8 shadow write ignored", d, 32'h1234_5678);
        wr(12'hB02, 32'hDEAD_BEEF, 2'd1, 1'b0);
        rd(12'hC02, 2'd0, d, ill); check("R5 R8 supervisor write ignored", d, 32'h1234_5678);
        wr(12'h320, 32'd5, 2'd0, 1'b0);
        rd(12'h320, 2'd3, d, ill); check("R8 user mask write ignored", d, 32'd0);
        rd(12'hB00, 2'd0, d, ill); check("R8 illegal read data zero", d, 32'd0);

        // R4 / R5 / R8: sweep privilege x write x address, predicted illegal
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int ai = 0; ai < 14; ai++) begin
                    logic [11:0] a;
                    logic exp_ill;
                    a = alist[ai];
                    exp_ill = (ai >= 9) || (p < a[9:8]) || (w == 1 && a[11:10] == 2'b11);
                    @(negedge clk);
                    csr_addr_i = a; priv_i = p[1:0]; csr_we_i = w[0]; csr_wdata_i = 32'd0;
                    #2;
                    check("R4 R5 R8 access sweep", {31'd0, illegal_o}, {31'd0, exp_ill});
                    csr_we_i = 1'b0;
                end
            end
        end

        finish_run();
    end

endmodule